// File: doc/BRIEF.md
# Vector Sum Reduction by Halving

This block sums a long stream of integer vectors into a single scalar. Each accepted input chunk carries `LANES` elements. Every element is added into its own running partial sum, so the loop-carried dependence of a serial accumulator is split into `LANES` independent chains. All lanes update in the same cycle.

When the finish command is accepted, the unit folds the partial sums. At each step the upper half of the live partial sums is added onto the lower half, and the live length is halved. After `log2(LANES)` single-cycle steps, lane 0 holds the total. The total is presented for one cycle with a valid pulse. The partial sums are then cleared, and the unit accepts the next reduction at once.

Arithmetic is two's-complement integer addition that wraps at `WIDTH` bits. `LANES` must be a power of two, at least 2.

Top module: `vsr_reduce`

## Requirements
- R1: Out of reset, `in_ready` is 1 and `res_valid` is 0.
- R2: A chunk is accepted in a cycle with `in_valid` and `in_ready` both high. Element `l` sits in bits `[l*WIDTH +: WIDTH]` of `in_data` and is added only into partial sum `l`.
- R3: Every addition wraps modulo 2^WIDTH.
- R4: When finish is accepted (`fin` high while `in_ready` is high), `in_ready` goes low for exactly log2(LANES) cycles, which is 3 with the default parameters.
- R5: The result equals the wrapped sum of every element of every chunk accepted since the previous result.
- R6: `res_valid` is high for exactly one cycle. It rises log2(LANES) clock edges after the edge that accepts finish.
- R7: In the result cycle `in_ready` is already high again. All partial sums are zero, so the next reduction starts from zero.
- R8: `in_valid` is ignored while folding, and the data offered then never reaches any result.
- R9: A chunk offered in the same cycle as an accepted finish is included in that result.
- R10: A finish with no chunk accepted since the previous result gives a result of 0.
- R11: `fin` asserted while folding is ignored and produces no extra result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input chunk offered |
| in_ready | output | 1 | Unit can take a chunk or a finish command |
| in_data | input | LANES*WIDTH | Chunk of LANES elements, element l at bits [l*WIDTH +: WIDTH] |
| fin | input | 1 | Finish command; starts folding when accepted |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | WIDTH | Reduced scalar |

## Verification
The bench uses the default 8 lanes of 16 bits. This gives a three-step fold, so the ready-low window and the result position can be counted edge by edge. The narrow width lets a few all-ones chunks push the total past 2^16, which exercises wraparound. One-hot lane values (lane l carries 2^l) make a lost or misrouted lane visible in the total. Chunks and finish commands are also driven during the fold, to show that they are ignored.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
    typedef enum logic [0:0] {
        ST_ACC  = 1'b0,
        ST_FOLD = 1'b1
    } vsr_state_e;
endpackage

// File: rtl/vsr_lane_acc.sv
// Element-wise accumulation of one input chunk into the partial sums.
module vsr_lane_acc #(
    parameter int LANES = 8,
    parameter int WIDTH = 16
) (
    input  logic [LANES-1:0][WIDTH-1:0] part_i,
    input  logic [LANES*WIDTH-1:0]      chunk_i,
    output logic [LANES-1:0][WIDTH-1:0] sum_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign sum_o[l] = part_i[l] + chunk_i[l*WIDTH +: WIDTH];
    end
endmodule

// File: rtl/vsr_fold_step.sv
// One halving step: lanes below the new live length take the lane one
// half-length above them; other lanes are passed through.
module vsr_fold_step #(
    parameter int LANES = 8,
    parameter int WIDTH = 16,
    parameter int CW    = 2
) (
    input  logic [LANES-1:0][WIDTH-1:0] part_i,
    input  logic [CW-1:0]               step_i,
    output logic [LANES-1:0][WIDTH-1:0] fold_o
);
    localparam int IW = $clog2(LANES);

    int unsigned half;
    logic [IW-1:0] src;

    always_comb begin
        half = LANES >> (int'(step_i) + 1);
        src  = '0;
        for (int j = 0; j < LANES; j++) begin
            if (j < int'(half)) begin
                src       = IW'(j + int'(half));
                fold_o[j] = part_i[j] + part_i[src];
            end else begin
                fold_o[j] = part_i[j];
            end
        end
    end
endmodule

// File: rtl/vsr_reduce.sv
// Streaming vector sum with halving-tree final reduction.
module vsr_reduce
    import vsr_pkg::*;
#(
    parameter int LANES = 8,
    parameter int WIDTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [LANES*WIDTH-1:0] in_data,
    input  logic                   fin,
    output logic                   res_valid,
    output logic [WIDTH-1:0]       res_data
);
    localparam int STEPS = $clog2(LANES);
    localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(STEPS - 1);

    typedef struct packed {
        vsr_state_e                  st;
        logic [CW-1:0]               step;
        logic [LANES-1:0][WIDTH-1:0] part;
        logic [WIDTH-1:0]            res;
        logic                        res_vld;
    } regs_t;

    regs_t r_q, r_d;

    logic [LANES-1:0][WIDTH-1:0] acc_sum;
    logic [LANES-1:0][WIDTH-1:0] fold_sum;
    logic                        ready_int;
    logic                        take;

    vsr_lane_acc #(.LANES(LANES), .WIDTH(WIDTH)) u_acc (
        .part_i (r_q.part),
        .chunk_i(in_data),
        .sum_o  (acc_sum)
    );

    vsr_fold_step #(.LANES(LANES), .WIDTH(WIDTH), .CW(CW)) u_fold (
        .part_i(r_q.part),
        .step_i(r_q.step),
        .fold_o(fold_sum)
    );

    assign ready_int = (r_q.st == ST_ACC);
    assign take      = in_valid && ready_int;

    always_comb begin
        r_d         = r_q;
        r_d.res_vld = 1'b0;
        unique case (r_q.st)
            ST_ACC: begin
                if (take) begin
                    r_d.part = acc_sum;
                end
                if (fin) begin
                    r_d.st   = ST_FOLD;
                    r_d.step = '0;
                end
            end
            ST_FOLD: begin
                r_d.part = fold_sum;
                if (r_q.step == LAST_STEP) begin
                    r_d.res     = fold_sum[0];
                    r_d.res_vld = 1'b1;
                    r_d.part    = '0;
                    r_d.step    = '0;
                    r_d.st      = ST_ACC;
                end else begin
                    r_d.step = r_q.step + 1'b1;
                end
            end
            default: r_d.st = ST_ACC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_ACC, step: '0, part: '0, res: '0, res_vld: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready  = ready_int;
    assign res_valid = r_q.res_vld;
    assign res_data  = r_q.res;
endmodule

// File: rtl/vsr_reduce_chk.sv
// Protocol and timing checks for vsr_reduce, attached by bind.
module vsr_reduce_chk #(
    parameter int LANES = 8,
    parameter int WIDTH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic [LANES*WIDTH-1:0] in_data,
    input logic                   fin,
    input logic                   res_valid,
    input logic [WIDTH-1:0]       res_data
);
    localparam int STEPS = $clog2(LANES);
    localparam int BW    = $clog2(STEPS + 1) + 1;

    logic [BW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (!in_ready) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    // R4
    fin_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && in_ready) |=> !in_ready);

    // R4
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= BW'(STEPS));

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R6
    result_after_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (busy_cnt == BW'(STEPS)));

    // R7
    ready_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> in_ready);

    // R11
    no_result_in_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> !res_valid);
endmodule

bind vsr_reduce vsr_reduce_chk #(.LANES(LANES), .WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .fin      (fin),
    .res_valid(res_valid),
    .res_data (res_data)
);

// File: tb/vsr_reduce_bench.sv
module vsr_reduce_bench;
    localparam int LANES = 8;
    localparam int WIDTH = 16;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic                   in_ready;
    logic [LANES*WIDTH-1:0] in_data = '0;
    logic                   fin = 1'b0;
    logic                   res_valid;
    logic [WIDTH-1:0]       res_data;

    int total = 0;
    int bad = 0;
    logic [WIDTH-1:0] exp_q[$];
    logic [WIDTH-1:0] run_sum = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vsr_reduce #(.LANES(LANES), .WIDTH(WIDTH)) u_vsr_reduce (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .fin(fin), .res_valid(res_valid), .res_data(res_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WIDTH-1:0] chunk_total(input logic [LANES*WIDTH-1:0] d);
        logic [WIDTH-1:0] s = '0;
        for (int l = 0; l < LANES; l++) s = s + d[l*WIDTH +: WIDTH];
        return s;
    endfunction

    // R2: drive one chunk; expected total tracked independently
    task automatic send(input logic [LANES*WIDTH-1:0] d);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        run_sum  = run_sum + chunk_total(d);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic random_chunk(output logic [LANES*WIDTH-1:0] d);
        for (int l = 0; l < LANES; l++) d[l*WIDTH +: WIDTH] = WIDTH'($urandom);
    endtask

    // R4 R6 R8 R9 R11: finish, then watch the fold window edge by edge
    task automatic finish(input bit with_chunk, input logic [LANES*WIDTH-1:0] d,
                          input bit poke);
        logic [LANES*WIDTH-1:0] junk;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        fin = 1'b1;
        if (with_chunk) begin
            in_valid = 1'b1;
            in_data  = d;
            run_sum  = run_sum + chunk_total(d);
        end
        exp_q.push_back(run_sum);
        run_sum = '0;
        for (int c = 1; c <= 3; c++) begin
            @(negedge clk);
            check(in_ready == 1'b0, "R4", "ready low during fold", in_ready, 0);
            check(res_valid == 1'b0, "R6", "no early result", res_valid, 0);
            if (poke && c < 3) begin
                random_chunk(junk);
                in_valid = 1'b1;
                in_data  = junk;
                fin      = 1'b1;
            end else begin
                in_valid = 1'b0;
                fin      = 1'b0;
            end
        end
        @(negedge clk);
        check(res_valid == 1'b1, "R6", "result strobe position", res_valid, 1);
        check(in_ready == 1'b1, "R7", "ready back with result", in_ready, 1);
        @(negedge clk);
        check(res_valid == 1'b0, "R6", "strobe one cycle", res_valid, 0);
    endtask

    // scoreboard monitor, R5
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected result", res_data, 0);
            end else begin
                logic [WIDTH-1:0] e;
                e = exp_q.pop_front();
                check(res_data == e, "R5", "result value", res_data, e);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [LANES*WIDTH-1:0] d;
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
        check(res_valid == 1'b0, "R1", "no result in reset", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "ready out of reset", in_ready, 1);
        check(res_valid == 1'b0, "R1", "no result out of reset", res_valid, 0);

        // R2: one-hot lane weights, total 255 exposes any lost lane
        for (int l = 0; l < LANES; l++) d[l*WIDTH +: WIDTH] = WIDTH'(1 << l);
        send(d);
        finish(1'b0, '0, 1'b0);

        // R5 R8 R11: random chunks, traffic injected during fold
        for (int k = 0; k < 4; k++) begin
            random_chunk(d);
            send(d);
        end
        finish(1'b0, '0, 1'b1);

        // R3: wraparound with all-ones lanes
        d = '1;
        repeat (3) send(d);
        finish(1'b0, '0, 1'b0);

        // R9: chunk together with finish
        random_chunk(d);
        send(d);
        random_chunk(d);
        finish(1'b1, d, 1'b0);

        // R7 R10: nothing sent since last result gives zero
        finish(1'b0, '0, 1'b0);

        // back-to-back reductions with random contents
        for (int r = 0; r < 5; r++) begin
            for (int k = 0; k <= r; k++) begin
                random_chunk(d);
                send(d);
            end
            finish(1'b0, '0, r[0]);
        end

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5", "all results seen", exp_q.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule